// File: doc/BRIEF.md
# Dual Converter Result Packer

This block sits between two paired analog-to-digital converters, one acting as master and one as slave, and a DMA engine. Each converter hands over a result with a one-cycle valid strobe. The block holds the latest result from each side and, once it has one from both, offers them to the DMA engine as a single combined word with a request line. The DMA engine reads that word by pulsing an acknowledge, which releases both held results.

A mode field picks the packing. With no packing, results are still captured but no request is ever raised. In full-width pairing, the combined word carries both complete results. In byte pairing, two 8-bit results share one half-word. Byte pairing is only meaningful at 6-bit resolution, or at 8-bit resolution with unsigned results and no offsets; the block does not check this.

A result that arrives on a side whose previous result is still unread is an overrun. An overrun locks out all further requests until software clears the lock or leaves paired operation, so memory only ever receives whole, valid pairs. A single shared bit picks between one-shot transfers, which stop after a programmed number of pairs, and circular transfers, which run on without limit.

Top module: `pair_packer`

## Requirements
- R1: After reset, `dma_req`, `ovr_lock`, `xfer_done`, both result-held flags and the combined word are all 0.
- R2: In a pairing mode (`mode` 2'b10 or 2'b11), `dma_req` is high in the cycle after results are held from both the master and the slave, in either arrival order or together, and stays low while only one side is held.
- R3: In full-width pairing (`mode` = 2'b10), `pair_word` bits 31:16 hold the slave result and bits 15:0 hold the master result.
- R4: In byte pairing (`mode` = 2'b11), `pair_word` bits 15:8 hold the slave result's low byte, bits 7:0 hold the master result's low byte, and bits 31:16 are 0.
- R5: With no packing (`mode` 2'b00 or 2'b01), results are still captured and flagged as held, but `dma_req` stays low, `pair_word` reads 0 and no overrun is recorded.
- R6: A `rd_ack` pulse while `dma_req` is high clears both held flags, so `dma_req` falls in the following cycle.
- R7: In a pairing mode, a new result on a side that still holds an unread one sets `ovr_lock` in the next cycle; the new result is dropped, the held result and its held flag stay, and `dma_req` stays low while the lock is set.
- R8: `ovr_lock` is cleared in the cycle after `clr_ovr` is pulsed or `mode` selects no packing; the clear takes priority over a new overrun in the same cycle.
- R9: With `circular` low, after `xfer_limit` acknowledged pairs `dma_req` stays low and `xfer_done` is high; with `circular` high, requests keep coming past that count.
- R10: A `restart` pulse sets the transfer count back to zero, so a pending pair held back by the one-shot limit is requested again.
- R11: A new result arriving in the same cycle as an acknowledged read of its side is captured as a fresh held result and is not an overrun.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Packing mode: 00/01 none, 10 full-width, 11 byte |
| circular | input | 1 | 1 = circular transfers, 0 = one-shot |
| xfer_limit | input | CW | Number of pairs allowed in one-shot operation |
| restart | input | 1 | Pulse: reset the transfer count |
| clr_ovr | input | 1 | Pulse: clear the overrun lock |
| mst_vld | input | 1 | Master result strobe |
| mst_data | input | DW | Master result |
| slv_vld | input | 1 | Slave result strobe |
| slv_data | input | DW | Slave result |
| rd_ack | input | 1 | DMA read of the combined word |
| pair_word | output | 2*DW | Combined data word |
| dma_req | output | 1 | DMA request: a complete pair is ready |
| ovr_lock | output | 1 | Overrun lock is set |
| mst_held | output | 1 | A master result is held (end of conversion) |
| slv_held | output | 1 | A slave result is held (end of conversion) |
| xfer_done | output | 1 | One-shot transfer count reached |

## Verification
Both pairing modes are swept with master-first, slave-first and simultaneous arrival over several data values, whose bit patterns differ between the low and high bytes. That tells apart a wrong pairing order, a swapped half and a byte packing that leaks upper bits. The no-packing mode gets the same arrivals to show that capture happens without a request. Repeated master results and repeated slave results separate the overrun path on each side from an acknowledge that lands in the same cycle. One-shot runs at a small limit, circular runs past that limit, and a restart show where the count stops and starts requests.

// File: rtl/pair_packer_pkg.sv
package pair_packer_pkg;

  typedef enum logic [1:0] {
    PK_NONE = 2'b00,
    PK_RSVD = 2'b01,
    PK_WIDE = 2'b10,
    PK_BYTE = 2'b11
  } pk_mode_t;

  function automatic logic is_paired(input pk_mode_t md);
    return (md == PK_WIDE) || (md == PK_BYTE);
  endfunction

endpackage

// File: rtl/pp_slot.sv
module pp_slot #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vld,
  input  logic [DW-1:0] data,
  input  logic          take,
  input  logic          guard,
  output logic          full,
  output logic [DW-1:0] q,
  output logic          ovr
);

  logic load;

  // a result is accepted when the slot is free, being read now, or unguarded
  assign load = vld && (!full || take || !guard);
  assign ovr  = vld && full && !take && guard;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full <= 1'b0;
      q    <= '0;
    end else if (load) begin
      full <= 1'b1;
      q    <= data;
    end else if (take) begin
      full <= 1'b0;
    end
  end

  // R7: a guarded, unread result is never replaced
  a_r7_keep_held: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !take && guard) |=> (full && $stable(q)));

  // R11: read and new result together reload the slot
  a_r11_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && take) |=> (full && q == $past(data)));

endmodule

// File: rtl/pp_ovr_guard.sv
module pp_ovr_guard (
  input  logic clk,
  input  logic rst_n,
  input  logic paired,
  input  logic clr,
  input  logic ovr_m,
  input  logic ovr_s,
  output logic lock
);

  logic any_ovr;
  logic wipe;

  assign any_ovr = ovr_m || ovr_s;
  assign wipe    = clr || !paired;

  always_ff @(posedge clk) begin
    if (!rst_n)       lock <= 1'b0;
    else if (wipe)    lock <= 1'b0;
    else if (any_ovr) lock <= 1'b1;
  end

  a_r7_lock_set: assert property (@(posedge clk) disable iff (!rst_n)
    (any_ovr && !wipe) |=> lock);

  a_r8_lock_clear: assert property (@(posedge clk) disable iff (!rst_n)
    wipe |=> !lock);

  a_r7_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && !wipe) |=> lock);

endmodule

// File: rtl/pp_xfer_ctl.sv
module pp_xfer_ctl #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  input  logic          circular,
  input  logic          restart,
  input  logic [CW-1:0] limit,
  output logic          done
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt <= '0;
    else if (restart) cnt <= '0;
    else if (fire)    cnt <= cnt + 1'b1;
  end

  assign done = !circular && (cnt >= limit);

  // R9: one-shot transfers never go past the limit
  a_r9_within_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !circular) |-> (cnt < limit));

  // R10: restart brings the count back to zero
  a_r10_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt == '0));

endmodule

// File: rtl/pair_packer.sv
module pair_packer
  import pair_packer_pkg::*;
#(
  parameter int DW = 16,
  parameter int CW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      mode,
  input  logic            circular,
  input  logic [CW-1:0]   xfer_limit,
  input  logic            restart,
  input  logic            clr_ovr,
  input  logic            mst_vld,
  input  logic [DW-1:0]   mst_data,
  input  logic            slv_vld,
  input  logic [DW-1:0]   slv_data,
  input  logic            rd_ack,
  output logic [2*DW-1:0] pair_word,
  output logic            dma_req,
  output logic            ovr_lock,
  output logic            mst_held,
  output logic            slv_held,
  output logic            xfer_done
);

  localparam int WW = 2 * DW;
  localparam int PADW = WW - 16;

  function automatic logic [WW-1:0] pack_word(input pk_mode_t md,
                                              input logic [DW-1:0] m,
                                              input logic [DW-1:0] s);
    logic [WW-1:0] w;
    w = '0;
    case (md)
      PK_WIDE: w = {s, m};
      PK_BYTE: w = {{PADW{1'b0}}, s[7:0], m[7:0]};
      default: w = '0;
    endcase
    return w;
  endfunction

  pk_mode_t      md;
  logic          paired;
  logic          fire;
  logic          ovr_m, ovr_s;
  logic [DW-1:0] m_q, s_q;

  assign md     = pk_mode_t'(mode);
  assign paired = is_paired(md);

  pp_slot #(.DW(DW)) u_mst (
    .clk(clk), .rst_n(rst_n), .vld(mst_vld), .data(mst_data),
    .take(fire), .guard(paired), .full(mst_held), .q(m_q), .ovr(ovr_m));

  pp_slot #(.DW(DW)) u_slv (
    .clk(clk), .rst_n(rst_n), .vld(slv_vld), .data(slv_data),
    .take(fire), .guard(paired), .full(slv_held), .q(s_q), .ovr(ovr_s));

  pp_ovr_guard u_guard (
    .clk(clk), .rst_n(rst_n), .paired(paired), .clr(clr_ovr),
    .ovr_m(ovr_m), .ovr_s(ovr_s), .lock(ovr_lock));

  pp_xfer_ctl #(.CW(CW)) u_xfer (
    .clk(clk), .rst_n(rst_n), .fire(fire), .circular(circular),
    .restart(restart), .limit(xfer_limit), .done(xfer_done));

  assign dma_req   = paired && mst_held && slv_held && !ovr_lock && !xfer_done;
  assign fire      = dma_req && rd_ack;
  assign pair_word = pack_word(md, m_q, s_q);

  a_r2_req_has_pair: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> (mst_held && slv_held && !ovr_lock));

  a_r5_none_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !paired |-> (!dma_req && !ovr_m && !ovr_s));

  a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !mst_vld && !slv_vld) |=> (!mst_held && !slv_held));

endmodule

// File: tb/sim_pair_packer.sv
`timescale 1ns/1ps
module sim_pair_packer;

  localparam int DW = 16;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    mode = 2'b00;
  logic          circular = 1'b1;
  logic [CW-1:0] xfer_limit = '0;
  logic          restart = 1'b0;
  logic          clr_ovr = 1'b0;
  logic          mst_vld = 1'b0;
  logic [DW-1:0] mst_data = '0;
  logic          slv_vld = 1'b0;
  logic [DW-1:0] slv_data = '0;
  logic          rd_ack = 1'b0;
  logic [2*DW-1:0] pair_word;
  logic          dma_req, ovr_lock, mst_held, slv_held, xfer_done;

  int n_run = 0;
  int n_bad = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  pair_packer #(.DW(DW), .CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .mode(mode), .circular(circular),
    .xfer_limit(xfer_limit), .restart(restart), .clr_ovr(clr_ovr),
    .mst_vld(mst_vld), .mst_data(mst_data), .slv_vld(slv_vld),
    .slv_data(slv_data), .rd_ack(rd_ack), .pair_word(pair_word),
    .dma_req(dma_req), .ovr_lock(ovr_lock), .mst_held(mst_held),
    .slv_held(slv_held), .xfer_done(xfer_done));

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: actual still running, expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run = n_run + 1;
    if (act !== exp) begin
      n_bad = n_bad + 1;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    step(); step();
    rst_n = 1'b1;
    step();
  endtask

  task automatic put(input logic mv, input logic [DW-1:0] md_, input logic sv, input logic [DW-1:0] sd);
    mst_vld = mv; mst_data = md_;
    slv_vld = sv; slv_data = sd;
    step();
    mst_vld = 1'b0; slv_vld = 1'b0;
  endtask

  task automatic ack();
    rd_ack = 1'b1;
    step();
    rd_ack = 1'b0;
  endtask

  function automatic logic [31:0] expect_word(input logic [1:0] md_, input logic [15:0] m, input logic [15:0] s);
    if (md_ == 2'b10) return s * 32'd65536 + m;
    if (md_ == 2'b11) return (s % 256) * 32'd256 + (m % 256);
    return 32'd0;
  endfunction

  initial begin
    logic [15:0] m, s;
    do_reset();
    // R1 reset state
    chk("R1 req", {31'd0, dma_req}, 0);
    chk("R1 lock", {31'd0, ovr_lock}, 0);
    chk("R1 held", {30'd0, mst_held, slv_held}, 0);
    chk("R1 done", {31'd0, xfer_done}, 0);
    chk("R1 word", pair_word, 0);

    // R2/R3/R4/R6 sweep: modes x arrival order x data
    circular = 1'b1;
    for (int mi = 2; mi < 4; mi++) begin
      mode = mi[1:0];
      step();
      for (int ord = 0; ord < 3; ord++) begin
        for (int k = 0; k < 4; k++) begin
          m = 16'h1234 + 16'(k) * 16'h2345;
          s = 16'hA5C3 ^ (16'(k) * 16'h0F1E);
          if (ord == 0) begin
            put(1, m, 0, 0);
            chk("R2 master only", {31'd0, dma_req}, 0);
            put(0, 0, 1, s);
          end else if (ord == 1) begin
            put(0, 0, 1, s);
            chk("R2 slave only", {31'd0, dma_req}, 0);
            put(1, m, 0, 0);
          end else begin
            put(1, m, 1, s);
          end
          chk("R2 pair req", {31'd0, dma_req}, 1);
          chk(mi == 2 ? "R3 wide word" : "R4 byte word", pair_word, expect_word(mi[1:0], m, s));
          ack();
          chk("R6 cleared", {29'd0, mst_held, slv_held, dma_req}, 0);
        end
      end
    end

    // R5 no packing
    for (int mi = 0; mi < 2; mi++) begin
      do_reset();
      mode = mi[1:0];
      put(1, 16'h4321, 1, 16'h8765);
      chk("R5 held", {30'd0, mst_held, slv_held}, 3);
      chk("R5 no req", {31'd0, dma_req}, 0);
      chk("R5 word zero", pair_word, 0);
      put(1, 16'h1111, 1, 16'h2222);
      chk("R5 no overrun", {31'd0, ovr_lock}, 0);
    end

    // R7 overrun on master, then R8 clear by clr_ovr
    do_reset();
    mode = 2'b10;
    put(1, 16'h00AA, 0, 0);
    put(1, 16'h00BB, 0, 0);
    chk("R7 lock master", {31'd0, ovr_lock}, 1);
    chk("R7 held stays", {31'd0, mst_held}, 1);
    put(0, 0, 1, 16'h0C0C);
    chk("R7 req blocked", {31'd0, dma_req}, 0);
    chk("R7 kept data", pair_word, 32'h0C0C00AA);
    clr_ovr = 1'b1; step(); clr_ovr = 1'b0;
    chk("R8 clr", {31'd0, ovr_lock}, 0);
    chk("R8 req back", {31'd0, dma_req}, 1);
    ack();
    // overrun on slave, clear by leaving paired mode
    put(0, 0, 1, 16'h0001);
    put(0, 0, 1, 16'h0002);
    chk("R7 lock slave", {31'd0, ovr_lock}, 1);
    mode = 2'b00; step(); mode = 2'b10;
    chk("R8 mode clears", {31'd0, ovr_lock}, 0);
    // R8 clear wins over simultaneous overrun
    put(0, 0, 1, 16'h0003);
    clr_ovr = 1'b1;
    put(0, 0, 1, 16'h0004);
    clr_ovr = 1'b0;
    chk("R8 clear priority", {31'd0, ovr_lock}, 0);

    // R9 one-shot limit and R10 restart
    do_reset();
    mode = 2'b11; circular = 1'b0; xfer_limit = 8'd3;
    for (int i = 0; i < 3; i++) begin
      put(1, 16'(i), 1, 16'(i + 8));
      chk("R9 one-shot req", {31'd0, dma_req}, 1);
      ack();
    end
    chk("R9 done", {31'd0, xfer_done}, 1);
    put(1, 16'h0055, 1, 16'h0066);
    chk("R9 stopped", {31'd0, dma_req}, 0);
    restart = 1'b1; step(); restart = 1'b0;
    chk("R10 restart req", {31'd0, dma_req}, 1);
    chk("R10 word", pair_word, 32'h00006655);
    ack();
    circular = 1'b1;
    for (int i = 0; i < 6; i++) begin
      put(1, 16'(i), 1, 16'(i));
      chk("R9 circular req", {31'd0, dma_req}, 1);
      ack();
    end

    // R11 ack with new master result in same cycle
    do_reset();
    mode = 2'b10;
    put(1, 16'h1000, 1, 16'h2000);
    rd_ack = 1'b1;
    put(1, 16'h3000, 0, 0);
    rd_ack = 1'b0;
    chk("R11 no lock", {31'd0, ovr_lock}, 0);
    chk("R11 held", {30'd0, mst_held, slv_held}, 2);
    put(0, 0, 1, 16'h4000);
    chk("R11 new pair", pair_word, 32'h40003000);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

endmodule